// File: doc/BRIEF.md
# Coherence State Query Array with Epoch Access Tracking

This block holds the per-line metadata of a private, direct-mapped MESI data cache and lets software read it back. For every line it keeps a residency flag, a tag, the last stable coherence state, a pending-transition marker, and two epoch tracking bits: one set by local reads and one set by local writes. A single cache-wide flag records that a remote request took away a line the local thread had touched in the current epoch. The block holds no data, issues no fills or misses and models no interconnect. It only reacts to the events the surrounding cache controller reports to it.

The controller reports fills, evictions, local hit accesses, remote snoops (a remote read lowers M or E to S, a remote write makes the line Invalid) and the begin and end of coherence transitions. Software sends an epoch-clear command when each synchronisation-free region starts. Software also sends state queries with a block address. Each query returns a 3-bit state code together with the line's two tracking bits and the cache-wide downgrade flag. A race detector can therefore see, from one load-like operation, whether a line it used was taken away inside the epoch. A query never allocates a line.

Top module: `coh_query_meta`

## Requirements
- R1: After reset no line is resident: a query returns state code 4 (NotPresent) with both tracking bits and the downgrade flag at 0, and no eviction report is raised.
- R2: A query answers exactly one cycle after it is presented. A fill installs the line with its given stable state and cleared tracking bits. The state codes are Invalid=0, Shared=1, Exclusive=2, Modified=3. A query to the same index with another tag returns 4.
- R3: A local read hit sets the line's read bit. A local write hit sets the line's write bit and changes Exclusive into Modified.
- R4: A remote read changes Modified or Exclusive into Shared and leaves Shared unchanged. A remote write changes the line to Invalid. The line stays resident, so its query returns 0 and not 4.
- R5: The downgrade flag is set only when a remote request actually lowers the state of a line whose read or write bit is set. A lowering snoop on an untouched line leaves it clear, and so does a snoop that lowers nothing.
- R6: One epoch-clear command clears the read and write bits of every line and the downgrade flag in the same cycle. Coherence states are left unchanged.
- R7: After a transition begins (trnValid with trnFinish=0), queries return the last stable state. After it finishes (trnFinish=1), they return the target state given at the begin.
- R8: When a snoop and a query address the same line in the same cycle, the response shows the state and downgrade flag after the snoop.
- R9: An eviction makes the line non-resident and discards its tracking bits. One cycle later, evictValid pulses with evictLine = {tag, index} only if the line had its read or write bit set.
- R10: A query changes no state: repeated queries return identical results, and a query to a non-resident block leaves it non-resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| epochClr | input | 1 | Gang-clear of tracking bits and downgrade flag |
| fillValid | input | 1 | Install a line |
| fillLine | input | LINE_ADDR_W | Block address being installed |
| fillState | input | 2 | Stable state of the installed line (0..3) |
| lclValid | input | 1 | Local hit access |
| lclWrite | input | 1 | 1 = local write, 0 = local read |
| lclLine | input | LINE_ADDR_W | Block address of the local access |
| snpValid | input | 1 | Remote snoop |
| snpWrite | input | 1 | 1 = remote write (invalidate), 0 = remote read (downgrade) |
| snpLine | input | LINE_ADDR_W | Block address of the snoop |
| evValid | input | 1 | Evict a line |
| evLine | input | LINE_ADDR_W | Block address being evicted |
| trnValid | input | 1 | Coherence transition event |
| trnFinish | input | 1 | 0 = transition begins, 1 = transition completes |
| trnLine | input | LINE_ADDR_W | Block address of the transition |
| trnState | input | 2 | Target stable state of the transition |
| qryValid | input | 1 | State query |
| qryLine | input | LINE_ADDR_W | Block address queried |
| rspValid | output | 1 | Query response valid |
| rspState | output | 3 | State code 0..4 |
| rspRd | output | 1 | Line read in current epoch |
| rspWr | output | 1 | Line written in current epoch |
| rspDgd | output | 1 | Cache-wide downgrade flag |
| evictValid | output | 1 | Evicted line had been touched this epoch |
| evictLine | output | LINE_ADDR_W | Block address of that evicted line |

## Verification
Queries are made after fills of every stable state and after tag-mismatching lookups, so the bench can tell Invalid apart from NotPresent. Snoops are sent to touched and untouched lines, and to lines they can and cannot lower, which tells a correct downgrade-arming condition from one that fires on any snoop or ignores the tracking bits. A snoop is also issued together with a query to the same line, and lines are evicted both touched and untouched. These cases expose the wrong same-cycle priority and an eviction report raised without cause.

// File: rtl/coh_query_pkg.sv
package coh_query_pkg;

  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_S  = 3'd1,
    ST_E  = 3'd2,
    ST_M  = 3'd3,
    ST_NP = 3'd4
  } cohState_e;

  // Per-cycle strobes from the control to the metadata store
  typedef struct packed {
    logic fill;
    logic lcl;
    logic lclWr;
    logic snp;
    logic snpWr;
    logic evict;
    logic trnBeg;
    logic trnEnd;
    logic clrAll;
  } metaStrobe_t;

endpackage

// File: rtl/coh_meta_store.sv
module coh_meta_store
  import coh_query_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 10
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  metaStrobe_t                     stb,
  input  logic [IDX_W-1:0]                fillIdx,
  input  logic [TAG_W-1:0]                fillTag,
  input  cohState_e                       fillState,
  input  logic [IDX_W-1:0]                lclIdx,
  input  logic [IDX_W-1:0]                snpIdx,
  input  logic [IDX_W-1:0]                evIdx,
  input  logic [IDX_W-1:0]                trnIdx,
  input  cohState_e                       trnState,
  output logic [NUM_LINES-1:0]            curValid,
  output logic [NUM_LINES-1:0][TAG_W-1:0] curTag,
  output logic [NUM_LINES-1:0]            nxtValid,
  output logic [NUM_LINES-1:0][TAG_W-1:0] nxtTag,
  output cohState_e [NUM_LINES-1:0]       nxtState,
  output logic [NUM_LINES-1:0]            nxtRd,
  output logic [NUM_LINES-1:0]            nxtWr,
  output logic                            nxtDgd,
  output logic                            dgdFlag,
  output logic                            evRptValid,
  output logic [TAG_W+IDX_W-1:0]          evRptLine
);

  logic [NUM_LINES-1:0] lineDown;
  logic [NUM_LINES-1:0] lineEvRpt;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

    logic             validQ, rdQ, wrQ, trnQ;
    logic [TAG_W-1:0] tagQ;
    cohState_e        stateQ, tgtQ;

    logic             vN, rN, wN, trN, downN, evN, lowered;
    logic [TAG_W-1:0] tN;
    cohState_e        sN, tgN;

    // Event order inside one cycle: clear, fill, transition, local, snoop, evict
    always_comb begin
      vN      = validQ;
      tN      = tagQ;
      sN      = stateQ;
      rN      = rdQ;
      wN      = wrQ;
      trN     = trnQ;
      tgN     = tgtQ;
      downN   = 1'b0;
      evN     = 1'b0;
      lowered = 1'b0;
      if (stb.clrAll) begin
        rN = 1'b0;
        wN = 1'b0;
      end
      if (stb.fill && fillIdx == MY_IDX) begin
        vN  = 1'b1;
        tN  = fillTag;
        sN  = fillState;
        rN  = 1'b0;
        wN  = 1'b0;
        trN = 1'b0;
      end
      if (stb.trnBeg && trnIdx == MY_IDX) begin
        trN = 1'b1;
        tgN = trnState;
      end
      if (stb.trnEnd && trnIdx == MY_IDX && trN) begin
        sN  = tgN;
        trN = 1'b0;
      end
      if (stb.lcl && lclIdx == MY_IDX) begin
        if (stb.lclWr) begin
          wN = 1'b1;
          if (sN == ST_E) sN = ST_M;
        end else begin
          rN = 1'b1;
        end
      end
      if (stb.snp && snpIdx == MY_IDX) begin
        if (stb.snpWr) begin
          if (sN != ST_I) begin
            lowered = 1'b1;
            sN      = ST_I;
          end
        end else if (sN == ST_M || sN == ST_E) begin
          lowered = 1'b1;
          sN      = ST_S;
        end
        downN = lowered && (rN || wN);
      end
      if (stb.evict && evIdx == MY_IDX) begin
        evN = rN || wN;
        vN  = 1'b0;
        rN  = 1'b0;
        wN  = 1'b0;
        trN = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        tagQ   <= '0;
        stateQ <= ST_I;
        rdQ    <= 1'b0;
        wrQ    <= 1'b0;
        trnQ   <= 1'b0;
        tgtQ   <= ST_I;
      end else begin
        validQ <= vN;
        tagQ   <= tN;
        stateQ <= sN;
        rdQ    <= rN;
        wrQ    <= wN;
        trnQ   <= trN;
        tgtQ   <= tgN;
      end
    end

    assign curValid[g]  = validQ;
    assign curTag[g]    = tagQ;
    assign nxtValid[g]  = vN;
    assign nxtTag[g]    = tN;
    assign nxtState[g]  = sN;
    assign nxtRd[g]     = rN;
    assign nxtWr[g]     = wN;
    assign lineDown[g]  = downN;
    assign lineEvRpt[g] = evN;
  end

  assign nxtDgd = (stb.clrAll ? 1'b0 : dgdFlag) | (|lineDown);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dgdFlag    <= 1'b0;
      evRptValid <= 1'b0;
      evRptLine  <= '0;
    end else begin
      dgdFlag    <= nxtDgd;
      evRptValid <= |lineEvRpt;
      if (|lineEvRpt) evRptLine <= {curTag[evIdx], evIdx};
    end
  end

endmodule

// File: rtl/coh_meta_ctrl.sv
module coh_meta_ctrl
  import coh_query_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int IDX_W       = 4,
  parameter int TAG_W       = 10,
  parameter int LINE_ADDR_W = IDX_W + TAG_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            epochClr,
  input  logic                            fillValid,
  input  logic [LINE_ADDR_W-1:0]          fillLine,
  input  logic [1:0]                      fillState,
  input  logic                            lclValid,
  input  logic                            lclWrite,
  input  logic [LINE_ADDR_W-1:0]          lclLine,
  input  logic                            snpValid,
  input  logic                            snpWrite,
  input  logic [LINE_ADDR_W-1:0]          snpLine,
  input  logic                            evValid,
  input  logic [LINE_ADDR_W-1:0]          evLine,
  input  logic                            trnValid,
  input  logic                            trnFinish,
  input  logic [LINE_ADDR_W-1:0]          trnLine,
  input  logic [1:0]                      trnState,
  input  logic                            qryValid,
  input  logic [LINE_ADDR_W-1:0]          qryLine,
  input  logic [NUM_LINES-1:0]            curValid,
  input  logic [NUM_LINES-1:0][TAG_W-1:0] curTag,
  input  logic [NUM_LINES-1:0]            nxtValid,
  input  logic [NUM_LINES-1:0][TAG_W-1:0] nxtTag,
  input  cohState_e [NUM_LINES-1:0]       nxtState,
  input  logic [NUM_LINES-1:0]            nxtRd,
  input  logic [NUM_LINES-1:0]            nxtWr,
  input  logic                            nxtDgd,
  output metaStrobe_t                     stb,
  output logic [IDX_W-1:0]                fillIdx,
  output logic [TAG_W-1:0]                fillTag,
  output cohState_e                       fillSt,
  output logic [IDX_W-1:0]                lclIdx,
  output logic [IDX_W-1:0]                snpIdx,
  output logic [IDX_W-1:0]                evIdx,
  output logic [IDX_W-1:0]                trnIdx,
  output cohState_e                       trnSt,
  output logic                            rspValid,
  output cohState_e                       rspState,
  output logic                            rspRd,
  output logic                            rspWr,
  output logic                            rspDgd
);

  logic [TAG_W-1:0] lclTag, snpTag, evTag, trnTag, qryTag;
  logic [IDX_W-1:0] qryIdx;
  logic             lclHit, snpHit, evHit, trnHit, qryHit;

  assign fillIdx = fillLine[IDX_W-1:0];
  assign fillTag = fillLine[LINE_ADDR_W-1:IDX_W];
  assign lclIdx  = lclLine[IDX_W-1:0];
  assign lclTag  = lclLine[LINE_ADDR_W-1:IDX_W];
  assign snpIdx  = snpLine[IDX_W-1:0];
  assign snpTag  = snpLine[LINE_ADDR_W-1:IDX_W];
  assign evIdx   = evLine[IDX_W-1:0];
  assign evTag   = evLine[LINE_ADDR_W-1:IDX_W];
  assign trnIdx  = trnLine[IDX_W-1:0];
  assign trnTag  = trnLine[LINE_ADDR_W-1:IDX_W];
  assign qryIdx  = qryLine[IDX_W-1:0];
  assign qryTag  = qryLine[LINE_ADDR_W-1:IDX_W];

  assign fillSt = cohState_e'({1'b0, fillState});
  assign trnSt  = cohState_e'({1'b0, trnState});

  assign lclHit = curValid[lclIdx] && curTag[lclIdx] == lclTag;
  assign snpHit = curValid[snpIdx] && curTag[snpIdx] == snpTag;
  assign evHit  = curValid[evIdx]  && curTag[evIdx]  == evTag;
  assign trnHit = curValid[trnIdx] && curTag[trnIdx] == trnTag;

  always_comb begin
    stb.clrAll = epochClr;
    stb.fill   = fillValid;
    stb.lcl    = lclValid && lclHit;
    stb.lclWr  = lclWrite;
    stb.snp    = snpValid && snpHit;
    stb.snpWr  = snpWrite;
    stb.evict  = evValid && evHit;
    stb.trnBeg = trnValid && !trnFinish && trnHit;
    stb.trnEnd = trnValid && trnFinish && trnHit;
  end

  // Response reads the post-event view of the line, so same-cycle snoops are seen
  assign qryHit = nxtValid[qryIdx] && nxtTag[qryIdx] == qryTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspState <= ST_NP;
      rspRd    <= 1'b0;
      rspWr    <= 1'b0;
      rspDgd   <= 1'b0;
    end else begin
      rspValid <= qryValid;
      if (qryValid) begin
        rspState <= qryHit ? nxtState[qryIdx] : ST_NP;
        rspRd    <= qryHit && nxtRd[qryIdx];
        rspWr    <= qryHit && nxtWr[qryIdx];
        rspDgd   <= nxtDgd;
      end
    end
  end

endmodule

// File: rtl/coh_query_meta.sv
module coh_query_meta
  import coh_query_pkg::*;
#(
  parameter int LINE_ADDR_W = 14,
  parameter int NUM_LINES   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   epochClr,
  input  logic                   fillValid,
  input  logic [LINE_ADDR_W-1:0] fillLine,
  input  logic [1:0]             fillState,
  input  logic                   lclValid,
  input  logic                   lclWrite,
  input  logic [LINE_ADDR_W-1:0] lclLine,
  input  logic                   snpValid,
  input  logic                   snpWrite,
  input  logic [LINE_ADDR_W-1:0] snpLine,
  input  logic                   evValid,
  input  logic [LINE_ADDR_W-1:0] evLine,
  input  logic                   trnValid,
  input  logic                   trnFinish,
  input  logic [LINE_ADDR_W-1:0] trnLine,
  input  logic [1:0]             trnState,
  input  logic                   qryValid,
  input  logic [LINE_ADDR_W-1:0] qryLine,
  output logic                   rspValid,
  output logic [2:0]             rspState,
  output logic                   rspRd,
  output logic                   rspWr,
  output logic                   rspDgd,
  output logic                   evictValid,
  output logic [LINE_ADDR_W-1:0] evictLine
);

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = LINE_ADDR_W - IDX_W;

  metaStrobe_t                     stb;
  logic [IDX_W-1:0]                fillIdx, lclIdx, snpIdx, evIdx, trnIdx;
  logic [TAG_W-1:0]                fillTag;
  cohState_e                       fillSt, trnSt, rspStateE;
  logic [NUM_LINES-1:0]            curValid, nxtValid, nxtRd, nxtWr;
  logic [NUM_LINES-1:0][TAG_W-1:0] curTag, nxtTag;
  cohState_e [NUM_LINES-1:0]       nxtState;
  logic                            nxtDgd, dgdFlag;

  coh_meta_ctrl #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_ADDR_W(LINE_ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .epochClr(epochClr),
    .fillValid(fillValid), .fillLine(fillLine), .fillState(fillState),
    .lclValid(lclValid), .lclWrite(lclWrite), .lclLine(lclLine),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpLine(snpLine),
    .evValid(evValid), .evLine(evLine),
    .trnValid(trnValid), .trnFinish(trnFinish), .trnLine(trnLine), .trnState(trnState),
    .qryValid(qryValid), .qryLine(qryLine),
    .curValid(curValid), .curTag(curTag),
    .nxtValid(nxtValid), .nxtTag(nxtTag), .nxtState(nxtState),
    .nxtRd(nxtRd), .nxtWr(nxtWr), .nxtDgd(nxtDgd),
    .stb(stb), .fillIdx(fillIdx), .fillTag(fillTag), .fillSt(fillSt),
    .lclIdx(lclIdx), .snpIdx(snpIdx), .evIdx(evIdx), .trnIdx(trnIdx), .trnSt(trnSt),
    .rspValid(rspValid), .rspState(rspStateE), .rspRd(rspRd), .rspWr(rspWr),
    .rspDgd(rspDgd)
  );

  coh_meta_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .stb(stb),
    .fillIdx(fillIdx), .fillTag(fillTag), .fillState(fillSt),
    .lclIdx(lclIdx), .snpIdx(snpIdx), .evIdx(evIdx), .trnIdx(trnIdx), .trnState(trnSt),
    .curValid(curValid), .curTag(curTag),
    .nxtValid(nxtValid), .nxtTag(nxtTag), .nxtState(nxtState),
    .nxtRd(nxtRd), .nxtWr(nxtWr), .nxtDgd(nxtDgd), .dgdFlag(dgdFlag),
    .evRptValid(evictValid), .evRptLine(evictLine)
  );

  assign rspState = rspStateE;

endmodule

// File: rtl/coh_query_meta_chk.sv
module coh_query_meta_chk (
  input logic       clk,
  input logic       rstN,
  input logic       qryValid,
  input logic       rspValid,
  input logic [2:0] rspState,
  input logic       rspRd,
  input logic       rspWr,
  input logic       snpValid,
  input logic       epochClr,
  input logic       evValid,
  input logic       evictValid,
  input logic       dgdFlag
);

  // R2: one response per query, one cycle later
  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    qryValid |=> rspValid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !qryValid |=> !rspValid);

  // R5: the downgrade flag can only rise on a cycle that carried a snoop
  assert_dgd_needs_snoop_R5: assert property (@(posedge clk) disable iff (!rstN)
    !snpValid |=> !$rose(dgdFlag));

  // R6: the epoch clear leaves the flag low
  assert_clear_drops_dgd_R6: assert property (@(posedge clk) disable iff (!rstN)
    epochClr |=> !dgdFlag);

  // R9: an eviction report follows only an eviction request
  assert_evict_report_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    !evValid |=> !evictValid);

  // R1: tracking bits are never reported for a non-resident block
  assert_np_has_no_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspState == 3'd4) |-> (!rspRd && !rspWr));

endmodule

bind coh_query_meta coh_query_meta_chk u_chk (
  .clk(clk), .rstN(rstN), .qryValid(qryValid), .rspValid(rspValid),
  .rspState(rspState), .rspRd(rspRd), .rspWr(rspWr), .snpValid(snpValid),
  .epochClr(epochClr), .evValid(evValid), .evictValid(evictValid),
  .dgdFlag(dgdFlag)
);

// File: tb/coh_query_meta_tb.sv
module coh_query_meta_tb;

  localparam int LA_W = 14;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            epochClr = 1'b0;
  logic            fillValid = 1'b0;
  logic [LA_W-1:0] fillLine = '0;
  logic [1:0]      fillState = '0;
  logic            lclValid = 1'b0, lclWrite = 1'b0;
  logic [LA_W-1:0] lclLine = '0;
  logic            snpValid = 1'b0, snpWrite = 1'b0;
  logic [LA_W-1:0] snpLine = '0;
  logic            evValid = 1'b0;
  logic [LA_W-1:0] evLine = '0;
  logic            trnValid = 1'b0, trnFinish = 1'b0;
  logic [LA_W-1:0] trnLine = '0;
  logic [1:0]      trnState = '0;
  logic            qryValid = 1'b0;
  logic [LA_W-1:0] qryLine = '0;
  logic            rspValid, rspRd, rspWr, rspDgd, evictValid;
  logic [2:0]      rspState;
  logic [LA_W-1:0] evictLine;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  coh_query_meta u_dut (
    .clk(clk), .rstN(rstN), .epochClr(epochClr),
    .fillValid(fillValid), .fillLine(fillLine), .fillState(fillState),
    .lclValid(lclValid), .lclWrite(lclWrite), .lclLine(lclLine),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpLine(snpLine),
    .evValid(evValid), .evLine(evLine),
    .trnValid(trnValid), .trnFinish(trnFinish), .trnLine(trnLine), .trnState(trnState),
    .qryValid(qryValid), .qryLine(qryLine),
    .rspValid(rspValid), .rspState(rspState), .rspRd(rspRd), .rspWr(rspWr),
    .rspDgd(rspDgd), .evictValid(evictValid), .evictLine(evictLine)
  );

  function automatic logic [LA_W-1:0] mk(input int tag, input int idx);
    return LA_W'(tag * 16 + idx);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // All drivers change just after a falling edge; outputs are read there too
  task automatic tick();
    @(negedge clk);
    epochClr = 1'b0; fillValid = 1'b0; lclValid = 1'b0; snpValid = 1'b0;
    evValid = 1'b0; trnValid = 1'b0; qryValid = 1'b0;
  endtask

  task automatic doFill(input logic [LA_W-1:0] a, input int st);
    fillValid = 1'b1; fillLine = a; fillState = 2'(st); tick();
  endtask

  task automatic doLcl(input logic [LA_W-1:0] a, input logic wr);
    lclValid = 1'b1; lclLine = a; lclWrite = wr; tick();
  endtask

  task automatic doSnp(input logic [LA_W-1:0] a, input logic wr);
    snpValid = 1'b1; snpLine = a; snpWrite = wr; tick();
  endtask

  task automatic doTrn(input logic [LA_W-1:0] a, input logic fin, input int st);
    trnValid = 1'b1; trnLine = a; trnFinish = fin; trnState = 2'(st); tick();
  endtask

  task automatic doClr();
    epochClr = 1'b1; tick();
  endtask

  task automatic doQry(input logic [LA_W-1:0] a);
    qryValid = 1'b1; qryLine = a; tick();
  endtask

  task automatic expQry(input string req, input logic [LA_W-1:0] a,
                        input int st, input int rd, input int wr, input int dg);
    doQry(a);
    chk(req, "rspValid", int'(rspValid), 1);
    chk(req, "rspState", int'(rspState), st);
    chk(req, "rspRd", int'(rspRd), rd);
    chk(req, "rspWr", int'(rspWr), wr);
    chk(req, "rspDgd", int'(rspDgd), dg);
  endtask

  task automatic t_reset();
    chk("R1", "evictValid", int'(evictValid), 0);
    chk("R1", "rspValid idle", int'(rspValid), 0);
    expQry("R1", mk(0, 0), 4, 0, 0, 0);
    expQry("R1", mk(5, 15), 4, 0, 0, 0);
  endtask

  task automatic t_fill();
    doFill(mk(1, 2), 2);
    expQry("R2", mk(1, 2), 2, 0, 0, 0);
    doFill(mk(2, 3), 1);
    doFill(mk(3, 4), 3);
    doFill(mk(4, 5), 0);
    expQry("R2", mk(2, 3), 1, 0, 0, 0);
    expQry("R2", mk(3, 4), 3, 0, 0, 0);
    expQry("R2", mk(4, 5), 0, 0, 0, 0);
    expQry("R2", mk(9, 2), 4, 0, 0, 0);
    chk("R2", "rspValid drops", int'(rspValid), 1);
    tick();
    chk("R2", "rspValid after idle", int'(rspValid), 0);
  endtask

  task automatic t_local();
    doLcl(mk(1, 2), 1'b0);
    expQry("R3", mk(1, 2), 2, 1, 0, 0);
    doLcl(mk(1, 2), 1'b1);
    expQry("R3", mk(1, 2), 3, 1, 1, 0);
    doLcl(mk(2, 3), 1'b1);
    expQry("R3", mk(2, 3), 1, 0, 1, 0);
  endtask

  task automatic t_snoop();
    doFill(mk(5, 6), 2);
    doSnp(mk(5, 6), 1'b0);
    expQry("R4", mk(5, 6), 1, 0, 0, 0);
    doSnp(mk(5, 6), 1'b1);
    expQry("R4", mk(5, 6), 0, 0, 0, 0);
    doFill(mk(6, 7), 1);
    doLcl(mk(6, 7), 1'b0);
    doSnp(mk(6, 7), 1'b0);
    expQry("R5", mk(6, 7), 1, 1, 0, 0);
    doSnp(mk(6, 7), 1'b1);
    expQry("R5", mk(6, 7), 0, 1, 0, 1);
  endtask

  task automatic t_clear();
    doClr();
    expQry("R6", mk(1, 2), 3, 0, 0, 0);
    expQry("R6", mk(2, 3), 1, 0, 0, 0);
  endtask

  task automatic t_transient();
    doFill(mk(7, 8), 1);
    doTrn(mk(7, 8), 1'b0, 3);
    expQry("R7", mk(7, 8), 1, 0, 0, 0);
    doTrn(mk(7, 8), 1'b1, 0);
    expQry("R7", mk(7, 8), 3, 0, 0, 0);
  endtask

  task automatic t_sameCycle();
    doFill(mk(8, 9), 3);
    doLcl(mk(8, 9), 1'b1);
    snpValid = 1'b1; snpLine = mk(8, 9); snpWrite = 1'b1;
    qryValid = 1'b1; qryLine = mk(8, 9);
    tick();
    chk("R8", "rspState", int'(rspState), 0);
    chk("R8", "rspWr", int'(rspWr), 1);
    chk("R8", "rspDgd", int'(rspDgd), 1);
    doClr();
  endtask

  task automatic t_evict();
    doFill(mk(10, 10), 2);
    doLcl(mk(10, 10), 1'b0);
    evValid = 1'b1; evLine = mk(10, 10); tick();
    chk("R9", "evictValid touched", int'(evictValid), 1);
    chk("R9", "evictLine", int'(evictLine), int'(mk(10, 10)));
    expQry("R9", mk(10, 10), 4, 0, 0, 0);
    chk("R9", "evictValid one pulse", int'(evictValid), 0);
    evValid = 1'b1; evLine = mk(3, 4); tick();
    chk("R9", "evictValid untouched", int'(evictValid), 0);
    expQry("R9", mk(3, 4), 4, 0, 0, 0);
  endtask

  task automatic t_queryPure();
    expQry("R10", mk(12, 11), 4, 0, 0, 0);
    expQry("R10", mk(12, 11), 4, 0, 0, 0);
    doLcl(mk(7, 8), 1'b0);
    expQry("R10", mk(7, 8), 3, 1, 0, 0);
    expQry("R10", mk(7, 8), 3, 1, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_local();
    t_snoop();
    t_clear();
    t_transient();
    t_sameCycle();
    t_evict();
    t_queryPure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule